// File: doc/BRIEF.md
# Serial Hold Condition Controller

This block sits beside the serial front-end of a flash-style slave. It gives a host a way to pause a transfer partway through without deselecting the slave. The block watches chip-select, the serial clock and the active-low hold request. All three arrive asynchronously and are brought into the system clock domain through synchronizers.

From these inputs the block keeps a hold flag, and derives two outputs from it:
- a shift enable that freezes the front-end's shift and bit-count logic;
- an override that forces the serial data output to high impedance.

Hold is taken and released only while the serial clock is low. A request that arrives while the clock is high is acted on at the next low phase. A rise of chip-select during hold aborts the transfer and clears the serial state. The transfer does not resume after such an abort.

A small bit-position tracker shows how the front-end uses the shift enable. It counts serial clock rising edges that are allowed through, and it exposes both the count and a per-edge shift strobe.

Top module: `hold_ctrl`

## Requirements
- R1: After reset: `hold_o`=0, `so_hiz_o`=0, `shift_en_o`=1, `cs_abort_o`=0, `bit_pos_o`=0.
- R2: With chip-select low (`cs_ni`=0), hold is entered when the hold request is low (`hold_ni`=0) and SCK is low. This includes the case where the request was already low when chip-select fell.
- R3: A hold request that goes low while SCK is high does not enter hold until SCK next goes low.
- R4: Hold is left when the hold request is high and SCK is low. A release seen while SCK is high takes effect when SCK next goes low.
- R5: While chip-select stays low and the hold request stays low, hold is kept whatever SCK does.
- R6: While held, `so_hiz_o`=1 and `shift_en_o`=0. SCK rising edges give no `sck_rise_o` strobe and do not change `bit_pos_o`.
- R7: A chip-select rise during hold clears hold and gives exactly one `cs_abort_o` pulse of one system cycle. It also clears `bit_pos_o` to 0. Hold is never entered while chip-select is high, and SCK edges then do not count.
- R8: `bit_pos_o` counts the allowed SCK rising edges modulo 2^CNT_W (8 by default). After hold is left, counting continues from the frozen value.
- R9: `hold_o`, `so_hiz_o` and `shift_en_o` change in the same system clock cycle. Each input change reaches them SYNC_STAGES+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip-select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| hold_ni | input | 1 | Hold request, active low, asynchronous |
| hold_o | output | 1 | Hold flag |
| shift_en_o | output | 1 | Clock enable for shift and bit-count logic |
| so_hiz_o | output | 1 | Forces the serial output to high impedance |
| cs_abort_o | output | 1 | One-cycle pulse when chip-select rises during hold |
| sck_rise_o | output | 1 | Allowed SCK rising-edge strobe |
| bit_pos_o | output | CNT_W | Current bit position in the transfer |

## Verification
The bench targets the deferred cases: it lowers the hold request while SCK is high, and later raises it while SCK is high. A design that ignored the SCK phase would enter or leave hold too early, and the high-phase check would catch it.

It toggles SCK during hold and then resumes. A design that did not freeze the counter would show an advanced bit position after the exit.

It raises chip-select in mid-hold. A design that resumed instead of aborting would keep the old position, would not pulse `cs_abort_o`, or would stay held.

A count past eight edges exposes a wrong wrap of the position counter.

// File: rtl/hold_pkg.sv
package hold_pkg;
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic hold_n;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);
  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  output logic held_o,
  output logic abort_o
);
  logic held_q, held_d;
  logic abort_q;

  always_comb begin
    if (cs_n_i)       held_d = 1'b0;
    else if (!held_q) held_d = !hold_n_i && !sck_i;
    else              held_d = !(hold_n_i && !sck_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      held_q  <= held_d;
      abort_q <= held_q && cs_n_i;
    end
  end

  assign held_o  = held_q;
  assign abort_o = abort_q;

  // R2
  hold_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held_q && !cs_n_i && !hold_n_i && !sck_i) |=> held_q);
  // R3
  hold_rise_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_q) |-> $past(!sck_i && !cs_n_i));
  // R4
  hold_fall_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_q) |-> $past(!sck_i || cs_n_i));
  // R5
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !cs_n_i && !hold_n_i) |=> held_q);
  // R7
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> !held_q);
  // R7
  abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |=> !abort_q);
endmodule

// File: rtl/hold_bitcnt.sv
module hold_bitcnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             clr_i,
  input  logic             en_i,
  output logic             rise_o,
  output logic [CNT_W-1:0] pos_o
);
  logic             sck_d_q;
  logic             rise_raw;
  logic [CNT_W-1:0] cnt_q;

  assign rise_raw = sck_i && !sck_d_q;
  assign rise_o   = rise_raw && en_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sck_d_q <= sck_i;
      if (clr_i)       cnt_q <= '0;
      else if (rise_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pos_o = cnt_q;

  // R6
  pos_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q));
  // R7
  pos_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic             hold_ni,
  output logic             hold_o,
  output logic             shift_en_o,
  output logic             so_hiz_o,
  output logic             cs_abort_o,
  output logic             sck_rise_o,
  output logic [CNT_W-1:0] bit_pos_o
);
  import hold_pkg::*;

  pins_t pins_raw, pins_s;
  logic  held;

  assign pins_raw = '{cs_n: cs_ni, sck: sck_i, hold_n: hold_ni};

  hold_sync #(
    .W      (PINS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  hold_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_i  (pins_s.cs_n),
    .sck_i   (pins_s.sck),
    .hold_n_i(pins_s.hold_n),
    .held_o  (held),
    .abort_o (cs_abort_o)
  );

  hold_bitcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sck_i (pins_s.sck),
    .clr_i (pins_s.cs_n),
    .en_i  (!held),
    .rise_o(sck_rise_o),
    .pos_o (bit_pos_o)
  );

  assign hold_o     = held;
  assign so_hiz_o   = held;
  assign shift_en_o = !held;

  // R6
  no_strobe_in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !sck_rise_o);
endmodule

// File: tb/tb_hold_ctrl.sv
module tb_hold_ctrl;
  localparam int SYNC  = 2;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck_i = 1'b0, hold_ni = 1'b1;
  logic hold_o, shift_en_o, so_hiz_o, cs_abort_o, sck_rise_o;
  logic [CNT_W-1:0] bit_pos_o;

  always #5 clk = ~clk;

  hold_ctrl #(.SYNC_STAGES(SYNC), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i), .hold_ni(hold_ni),
    .hold_o(hold_o), .shift_en_o(shift_en_o), .so_hiz_o(so_hiz_o),
    .cs_abort_o(cs_abort_o), .sck_rise_o(sck_rise_o), .bit_pos_o(bit_pos_o)
  );

  typedef struct {
    string tag;
    bit    hold;
    int    pos;
  } item_t;

  item_t exp_q[$];
  event  sample_ev;
  int    n_chk = 0, n_fail = 0;
  int    abort_cnt = 0, rise_cnt = 0;
  bit    done = 1'b0;

  always @(negedge clk) begin
    if (rst_ni && cs_abort_o) abort_cnt++;
    if (rst_ni && sck_rise_o) rise_cnt++;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against outputs
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        chk({it.tag, " hold_o"}, int'(hold_o), int'(it.hold));
        chk({it.tag, " so_hiz_o (R6)"}, int'(so_hiz_o), int'(it.hold));
        chk({it.tag, " shift_en_o (R6)"}, int'(shift_en_o), int'(!it.hold));
        chk({it.tag, " bit_pos_o"}, int'(bit_pos_o), it.pos);
      end
    end
  end

  task automatic settle();
    repeat (SYNC + 3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(bit cs, bit sck, bit hold);
    @(negedge clk);
    cs_ni = cs; sck_i = sck; hold_ni = hold;
    settle();
  endtask

  task automatic expect_out(string tag, bit hold, int pos);
    item_t it;
    it.tag = tag; it.hold = hold; it.pos = pos;
    exp_q.push_back(it);
    -> sample_ev;
    @(negedge clk);
  endtask

  task automatic pulse(int n, bit cs, bit hold);
    for (int i = 0; i < n; i++) begin
      drive(cs, 1'b1, hold);
      drive(cs, 1'b0, hold);
    end
  endtask

  initial begin
    int r0, a0;
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 1'b0, 0);
    chk("R1 cs_abort_o", int'(cs_abort_o), 0);
    rst_ni = 1'b1;
    settle();

    drive(1'b0, 1'b0, 1'b1);
    expect_out("R8 select", 1'b0, 0);
    pulse(3, 1'b0, 1'b1);
    expect_out("R8 three edges", 1'b0, 3);

    drive(1'b0, 1'b0, 1'b0);
    expect_out("R2 enter sck low", 1'b1, 3);
    r0 = rise_cnt;
    pulse(4, 1'b0, 1'b0);
    expect_out("R5 R6 held through sck", 1'b1, 3);
    chk("R6 no strobe in hold", rise_cnt - r0, 0);

    drive(1'b0, 1'b0, 1'b1);
    expect_out("R4 exit sck low", 1'b0, 3);
    pulse(1, 1'b0, 1'b1);
    expect_out("R8 resume from frozen", 1'b0, 4);

    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    expect_out("R3 deferred while sck high", 1'b0, 5);
    drive(1'b0, 1'b0, 1'b0);
    expect_out("R3 enter at sck low", 1'b1, 5);

    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1);
    expect_out("R4 exit deferred sck high", 1'b1, 5);
    drive(1'b0, 1'b0, 1'b1);
    expect_out("R4 exit at sck low", 1'b0, 5);

    pulse(5, 1'b0, 1'b1);
    expect_out("R8 wrap", 1'b0, 2);

    drive(1'b0, 1'b0, 1'b0);
    expect_out("R2 enter before abort", 1'b1, 2);
    a0 = abort_cnt;
    drive(1'b1, 1'b0, 1'b0);
    expect_out("R7 abort clears", 1'b0, 0);
    chk("R7 one abort pulse", abort_cnt - a0, 1);
    pulse(2, 1'b1, 1'b0);
    expect_out("R7 no hold or count while deselected", 1'b0, 0);

    drive(1'b0, 1'b0, 1'b1);
    pulse(1, 1'b0, 1'b1);
    expect_out("R7 restart from zero", 1'b0, 1);
    chk("R7 no extra abort", abort_cnt - a0, 1);

    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    expect_out("R2 request low at select", 1'b1, 0);

    // R9: outputs switch together, SYNC+1 cycles after the input change
    drive(1'b0, 1'b0, 1'b1);
    expect_out("R9 released", 1'b0, 0);
    @(negedge clk);
    hold_ni = 1'b0;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    chk("R9 hold_o not early", int'(hold_o), 0);
    @(negedge clk);
    chk("R9 hold_o on time", int'(hold_o), 1);
    chk("R9 so_hiz_o same cycle", int'(so_hiz_o), 1);
    chk("R9 shift_en_o same cycle", int'(shift_en_o), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule